// File: doc/BRIEF.md
# Output Impedance Code Update Scheduler

This block sits in the control path of a synchronous memory. It decides when a freshly measured output-driver impedance code gets copied into the register that drives the output stage. An external calibration circuit presents a candidate code at all times. The scheduler lets that code reach the drivers only on clock edges where the outputs are not being driven, and at most once per fixed window of clock cycles.

A free-running window divider counts every rising edge, whatever the memory is doing. Each time the window wraps, an update becomes pending. The pending update is applied on the first later edge that is quiet, meaning the part is deselected or output enable is inactive. The register then loads the whole new code in one step and raises a one-cycle strobe.

A separate counter tallies quiet edges after reset. Once enough of them have passed for the code to settle, it raises a sticky calibrated flag.

Top module: `imp_upd_sched`

## Requirements
- R1: While `rst` is high at a rising edge, and after it: `act_code` holds the mid-range default 2^(CODE_W-1), `upd_stb` is 0 and `calib_done` is 0.
- R2: The window divider advances on every rising edge, regardless of `desel`, `oe_n` or `cand_code`. With reset released and every edge quiet, the first transfer happens on the WIN_CYC+1-th edge after reset (edge 33 by default).
- R3: A transfer happens only on an edge where `desel`=1 or `oe_n`=1 is sampled, which is a quiet edge.
- R4: A pending update survives any number of edges with `desel`=0 and `oe_n`=0. It is applied on the first later quiet edge.
- R5: At most one transfer occurs per window. With every edge quiet, exactly one transfer occurs in every WIN_CYC edges.
- R6: `act_code` never changes on an edge where `desel`=0 and `oe_n`=0.
- R7: `upd_stb` is high for exactly the one cycle that follows the edge that loaded `act_code`, and is low otherwise.
- R8: `calib_done` rises after the SETTLE_CYC-th quiet edge since reset (1024 by default). It stays high until reset. Edges that drive the outputs are not counted.
- R9: On a transfer, `act_code` takes the value of `cand_code` sampled at that edge in a single step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| desel | input | 1 | 1 = memory deselected this cycle |
| oe_n | input | 1 | Output enable, active low; 1 = outputs off |
| cand_code | input | CODE_W | Candidate impedance code from calibration |
| act_code | output | CODE_W | Code applied to the output drivers |
| upd_stb | output | 1 | One-cycle pulse marking a code load |
| calib_done | output | 1 | Sticky flag: power-up settling complete |

## Verification
A divider that is off by one shifts the first strobe away from edge 33, and the per-cycle model comparison reports it within a single window. A pending flag that is lost or stuck shows as a missing strobe after a long read burst, or as extra strobes inside one window, on the first quiet edge where the model disagrees. A settle counter that counts read edges, or that wraps, makes `calib_done` rise early or drop. With the mixed traffic used, this surfaces within about a thousand cycles.

// File: rtl/imp_sched_pkg.sv
package imp_sched_pkg;

  typedef enum logic {
    CYC_DRIVE = 1'b0,
    CYC_QUIET = 1'b1
  } cyc_kind_e;

  // mid-range default code for a given code width
  function automatic int unsigned mid_code(input int unsigned w);
    return 32'd1 << (w - 1);
  endfunction

endpackage

// File: rtl/imp_win_div.sv
module imp_win_div #(
  parameter int unsigned WIN_CYC = 32
) (
  input  logic clk,
  input  logic rst,
  output logic wrap
);
  localparam int unsigned CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign wrap = (cnt == LAST);
endmodule

// File: rtl/imp_code_reg.sv
module imp_code_reg
  import imp_sched_pkg::*;
#(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrap,
  input  cyc_kind_e         kind,
  input  logic [CODE_W-1:0] cand,
  output logic [CODE_W-1:0] code_q,
  output logic              stb_q
);
  localparam logic [CODE_W-1:0] DEF_CODE = CODE_W'(mid_code(CODE_W));

  logic pend_q;
  logic xfer;

  assign xfer = pend_q && (kind == CYC_QUIET);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      code_q <= DEF_CODE;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= xfer;
      if (xfer) code_q <= cand;
      if (wrap)      pend_q <= 1'b1;
      else if (xfer) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/imp_settle_cnt.sv
module imp_settle_cnt
  import imp_sched_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 1024
) (
  input  logic      clk,
  input  logic      rst,
  input  cyc_kind_e kind,
  output logic      done_q
);
  generate
    if (SETTLE_CYC == 0) begin : g_none
      always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= 1'b1;
      end
    end else begin : g_cnt
      localparam int unsigned SW = $clog2(SETTLE_CYC + 1);
      localparam logic [SW-1:0] LAST = SW'(SETTLE_CYC - 1);
      logic [SW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt    <= '0;
          done_q <= 1'b0;
        end else if (kind == CYC_QUIET && !done_q) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) done_q <= 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/imp_upd_sched.sv
module imp_upd_sched
  import imp_sched_pkg::*;
#(
  parameter int unsigned CODE_W     = 6,
  parameter int unsigned WIN_CYC    = 32,
  parameter int unsigned SETTLE_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desel,
  input  logic              oe_n,
  input  logic [CODE_W-1:0] cand_code,
  output logic [CODE_W-1:0] act_code,
  output logic              upd_stb,
  output logic              calib_done
);
  cyc_kind_e kind;
  logic      wrap;

  assign kind = (desel || oe_n) ? CYC_QUIET : CYC_DRIVE;

  imp_win_div #(.WIN_CYC(WIN_CYC)) u_div (
    .clk  (clk),
    .rst  (rst),
    .wrap (wrap)
  );

  imp_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk    (clk),
    .rst    (rst),
    .wrap   (wrap),
    .kind   (kind),
    .cand   (cand_code),
    .code_q (act_code),
    .stb_q  (upd_stb)
  );

  imp_settle_cnt #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst    (rst),
    .kind   (kind),
    .done_q (calib_done)
  );
endmodule

// File: rtl/imp_sched_chk.sv
module imp_sched_chk #(
  parameter int unsigned CODE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              desel,
  input logic              oe_n,
  input logic [CODE_W-1:0] cand_code,
  input logic [CODE_W-1:0] act_code,
  input logic              upd_stb,
  input logic              calib_done
);
  a_r6_hold_on_read: assert property (@(posedge clk) disable iff (rst)
    (!desel && !oe_n) |=> $stable(act_code));

  a_r3_quiet_only: assert property (@(posedge clk) disable iff (rst)
    upd_stb |-> $past(desel || oe_n));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    upd_stb |=> !upd_stb);

  a_r7_change_has_strobe: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_code) |-> upd_stb);

  a_r9_takes_candidate: assert property (@(posedge clk) disable iff (rst)
    upd_stb |-> (act_code == $past(cand_code)));

  a_r8_sticky_calib: assert property (@(posedge clk) disable iff (rst)
    calib_done |=> calib_done);
endmodule

bind imp_upd_sched imp_sched_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .desel      (desel),
  .oe_n       (oe_n),
  .cand_code  (cand_code),
  .act_code   (act_code),
  .upd_stb    (upd_stb),
  .calib_done (calib_done)
);

// File: tb/test_imp_upd_sched.sv
`timescale 1ns/1ps
module test_imp_upd_sched;
  localparam int CW   = 6;
  localparam int WIN  = 32;
  localparam int SETL = 1024;
  localparam logic [CW-1:0] DEF = CW'(1 << (CW - 1));

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          desel = 1'b1;
  logic          oe_n = 1'b1;
  logic [CW-1:0] cand_code = '0;
  logic [CW-1:0] act_code;
  logic          upd_stb;
  logic          calib_done;

  int total = 0;
  int bad = 0;
  int edge_no = 0;
  int stb_cnt = 0;
  int first_stb = -1;
  bit done_flag = 0;

  // reference state, built from the requirements
  int          m_w;
  bit          m_pend;
  logic [CW-1:0] m_code;
  bit          m_stb;
  int          m_set;
  bit          m_cal;

  always #4 clk = ~clk;

  imp_upd_sched #(.CODE_W(CW), .WIN_CYC(WIN), .SETTLE_CYC(SETL)) i_imp_upd_sched (
    .clk(clk), .rst(rst), .desel(desel), .oe_n(oe_n), .cand_code(cand_code),
    .act_code(act_code), .upd_stb(upd_stb), .calib_done(calib_done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit quiet_of(input logic d, input logic o);
    return d || o;
  endfunction

  task automatic model_edge(input logic r, input logic d, input logic o, input logic [CW-1:0] c);
    bit q, x;
    if (r) begin
      m_w = 0; m_pend = 0; m_code = DEF; m_stb = 0; m_set = 0; m_cal = 0;
    end else begin
      q = quiet_of(d, o);
      x = m_pend && q;
      m_stb = x;
      if (x) m_code = c;
      if (m_w == WIN - 1) m_pend = 1; else if (x) m_pend = 0;
      m_w = (m_w + 1) % WIN;
      if (q && m_set < SETL) begin
        m_set++;
        if (m_set == SETL) m_cal = 1;
      end
    end
  endtask

  // one clock: drive, edge, model, compare away from edge
  task automatic step(input logic d, input logic o, input logic [CW-1:0] c);
    logic r;
    desel = d; oe_n = o; cand_code = c;
    r = rst;
    @(posedge clk);
    model_edge(r, d, o, c);
    if (!r) edge_no++;
    @(negedge clk);
    if (upd_stb) begin
      stb_cnt++;
      if (first_stb < 0) first_stb = edge_no;
    end
    check(act_code == m_code, "R6/R9 act_code", act_code, m_code);
    check(upd_stb == m_stb, "R7 upd_stb", upd_stb, m_stb);
    check(calib_done == m_cal, "R8 calib_done", calib_done, m_cal);
  endtask

  initial begin
    #(8 * 200000);
    if (!done_flag) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s;
    int base;
    logic [CW-1:0] held;
    s = $urandom(32'h1d5e);
    rst = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, CW'($urandom));
    // R1: reset state
    check(act_code == DEF, "R1 reset code", act_code, DEF);
    check(upd_stb == 1'b0, "R1 reset strobe", upd_stb, 0);
    check(calib_done == 1'b0, "R1 reset calib", calib_done, 0);
    rst = 1'b0;

    // R2: all quiet, first transfer on edge WIN+1
    for (int i = 0; i < WIN + 1; i++) step(1'b1, 1'b0, CW'($urandom));
    check(first_stb == WIN + 1, "R2 first transfer edge", first_stb, WIN + 1);

    // R4/R6: long read burst, nothing may change
    base = stb_cnt;
    held = act_code;
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0, CW'($urandom));
    check(stb_cnt == base, "R4 no transfer during reads", stb_cnt, base);
    check(act_code == held, "R6 code held over reads", act_code, held);
    // R4/R3: first quiet edge after reads applies the pending update
    step(1'b0, 1'b1, 6'h15);
    check(upd_stb == 1'b1, "R4 pending applied on quiet edge", upd_stb, 1);
    check(act_code == 6'h15, "R9 loaded candidate", act_code, 6'h15);

    // R5: all quiet for ten windows gives ten transfers
    base = stb_cnt;
    for (int i = 0; i < 10 * WIN; i++) step(1'b1, 1'b1, CW'($urandom));
    check(stb_cnt - base == 10, "R5 one transfer per window", stb_cnt - base, 10);
    check(calib_done == 1'b0, "R8 not yet settled", calib_done, 0);

    // mixed random traffic
    for (int i = 0; i < 1500; i++)
      step(1'($urandom % 2), 1'($urandom % 2), CW'($urandom));
    check(calib_done == 1'b1, "R8 settled after quiet edges", calib_done, 1);

    // R8: reads only, flag stays up
    for (int i = 0; i < 50; i++) step(1'b0, 1'b0, CW'($urandom));
    check(calib_done == 1'b1, "R8 flag sticky", calib_done, 1);

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule